// File: doc/BRIEF.md
# Hot-Plug I/O Expander Sequencer

This block keeps a switch's per-port hot-plug signals in step with an external I/O expander. The expander sits on the master SMBus. The block does not drive the bus bits itself. It hands whole transactions to an SMBus master engine through a simple request/done handshake, one data byte per transaction.

On the output side, the block watches the hot-plug output vector. When any bit differs from its value in the previous cycle, the block raises a pending-write flag. When it is free, it sends one write that carries the complete current output image. On the input side, it treats the active-low expander interrupt as a level. While that level is low and no write is pending, it reads the complete input image and presents the result as the hot-plug input vector. A failed transaction is retried once. A second failure drops the transaction and sets a sticky error flag.

The block also samples two groups of address strap pins once, on the first clock after reset is released. From them it forms the 7-bit master-side and slave-side SMBus addresses. No transaction starts until reset has been released and the configuration-done input is high.

Top module: `hpx_hotplug_seq`

## Requirements
- R1: One cycle after `hpOut` differs from its value in the previous cycle, a write is pending. When the block is idle and `cfgDone` is high, that write starts. The request carries `smbWrite`=1, `smbAddr`=EXP_ADDR and `smbCmd`=OUT_CMD. `smbWrData` holds the whole `hpOut` image as it stood in the launch cycle, zero-extended to 8 bits.
- R2: A change of `hpOut` while a transaction is running is not lost. After the running transaction completes, one more full-image write follows, carrying the newer value.
- R3: When the block is idle, no write is pending, `cfgDone` is high and `expIntN` is 0, a read starts with `smbWrite`=0 and `smbCmd`=IN_CMD. When the read completes without error, `hpIn` takes `smbRdData[IN_W-1:0]`. `hpIn` changes at no other time.
- R4: The interrupt is a level. If `expIntN` is still 0 when a read completes, a further read starts.
- R5: When a write is pending and the interrupt is low at the same time, the write is served before the read.
- R6: While `rstN` is low, or while `cfgDone` is low, `smbReq` stays 0.
- R7: A completion with `smbErr`=1 on the first attempt is followed by one cycle with `smbReq` low. The identical request is then issued again. If the retry also fails, the transaction is dropped, `errFlag` is set and the block returns to idle.
- R8: `errFlag` is 0 after reset. Once set, it stays 1 until the next reset.
- R9: `masterAddr` bits 3..0 are `strapMst[3:0]`, and bits 6..4 are the fixed pattern 1, 0, 1 (bit 6 first).
- R10: `slaveAddr` bits 2..0 are `strapSlv[2:0]`, bit 3 is 0, bit 4 is `strapSlv[3]`, and bits 6 and 5 are 1. Both addresses are captured once, on the first clock edge after reset is released. Later changes on the strap pins are ignored. Both addresses read 0 during reset.
- R11: `smbReq` stays high, with `smbWrite`, `smbCmd` and `smbWrData` unchanged, until the cycle in which `smbDone` is 1. In the cycle after `smbDone`, `smbReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgDone | input | 1 | Configuration loading finished; transactions allowed |
| hpOut | input | OUT_W | Hot-plug output image from the port logic |
| hpIn | output | IN_W | Hot-plug input image last read from the expander |
| expIntN | input | 1 | Active-low expander interrupt (level) |
| strapMst | input | 4 | Master-side address strap pins |
| strapSlv | input | 4 | Slave-side address strap pins |
| masterAddr | output | 7 | Captured master-side SMBus address |
| slaveAddr | output | 7 | Captured slave-side SMBus address |
| smbReq | output | 1 | Transaction request to the SMBus engine |
| smbWrite | output | 1 | 1 = write of the output image, 0 = read of the input image |
| smbAddr | output | 7 | Expander address (EXP_ADDR) |
| smbCmd | output | 8 | Expander register command byte |
| smbWrData | output | 8 | Output image byte for writes |
| smbDone | input | 1 | One-cycle completion pulse from the engine |
| smbErr | input | 1 | With smbDone: NAK or bus error |
| smbRdData | input | 8 | With smbDone: byte read from the expander |

## Verification
The assertions make three assumptions about the inputs:
- `cfgDone` never falls once it has risen.
- The engine raises `smbDone` only while `smbReq` is high.
- The engine drives `smbErr` and `smbRdData` only in the same cycle as `smbDone`.

The bench stays within these assumptions. Its engine responder counts a fixed latency over cycles in which `smbReq` is high and pulses `smbDone` for exactly one cycle. The bench raises `cfgDone` once and never lowers it. All inputs change only on the falling clock edge. The interrupt model releases `expIntN` only after a chosen number of successful reads. This lets a held-low level be tried without breaking the engine handshake.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_GAP  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic launch;
    logic launchWr;
    logic loadIn;
  } seqStrobe_t;
endpackage

// File: rtl/hpx_ctrl.sv
module hpx_ctrl
  import hpx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgDone,
  input  logic       outChanged,
  input  logic       expIntN,
  input  logic       smbDone,
  input  logic       smbErr,
  output seqStrobe_t strobe,
  output logic       smbReq,
  output logic       smbWrite,
  output logic       errFlag
);
  seqState_t state;
  logic pendWr;
  logic retried;
  logic idleGo, startWr, startRd;

  assign idleGo  = (state == ST_IDLE) && cfgDone;
  assign startWr = idleGo && pendWr;
  assign startRd = idleGo && !pendWr && !expIntN;
  assign smbReq  = (state == ST_BUSY);

  always_comb begin
    strobe.launch   = startWr || startRd;
    strobe.launchWr = startWr;
    strobe.loadIn   = (state == ST_BUSY) && smbDone && !smbErr && !smbWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pendWr   <= 1'b0;
      retried  <= 1'b0;
      smbWrite <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      pendWr <= (pendWr && !startWr) || outChanged;
      case (state)
        ST_IDLE: begin
          if (startWr || startRd) begin
            state    <= ST_BUSY;
            smbWrite <= startWr;
            retried  <= 1'b0;
          end
        end
        ST_BUSY: begin
          if (smbDone) begin
            if (!smbErr) begin
              state <= ST_IDLE;
            end else if (!retried) begin
              state   <= ST_GAP;
              retried <= 1'b1;
            end else begin
              state   <= ST_IDLE;
              errFlag <= 1'b1;
            end
          end
        end
        ST_GAP:  state <= ST_BUSY;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: error flag never clears outside reset
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R5: a pending write wins over the interrupt at launch
  p_write_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && cfgDone && pendWr) |=> (smbReq && smbWrite));

  // R6: nothing starts before configuration completes
  p_no_start_unconfigured_r6: assert property (@(posedge clk) disable iff (!rstN)
    !cfgDone |=> !smbReq);
endmodule

// File: rtl/hpx_dp.sv
module hpx_dp
  import hpx_pkg::*;
#(
  parameter int          OUT_W   = 8,
  parameter int          IN_W    = 8,
  parameter logic [7:0]  OUT_CMD = 8'h02,
  parameter logic [7:0]  IN_CMD  = 8'h00
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [OUT_W-1:0] hpOut,
  input  logic [7:0]       smbRdData,
  input  logic [3:0]       strapMst,
  input  logic [3:0]       strapSlv,
  output logic             outChanged,
  output logic [7:0]       smbCmd,
  output logic [7:0]       smbWrData,
  output logic [IN_W-1:0]  hpIn,
  output logic [6:0]       masterAddr,
  output logic [6:0]       slaveAddr
);
  logic [OUT_W-1:0] lastOut;
  logic [7:0]       outByte;
  logic             capDone;

  assign outChanged = (hpOut != lastOut);

  always_comb begin
    outByte = '0;
    outByte[OUT_W-1:0] = hpOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastOut   <= '0;
      smbCmd    <= '0;
      smbWrData <= '0;
      hpIn      <= '0;
    end else begin
      lastOut <= hpOut;
      if (strobe.launch) smbCmd <= strobe.launchWr ? OUT_CMD : IN_CMD;
      if (strobe.launchWr) smbWrData <= outByte;
      if (strobe.loadIn) hpIn <= smbRdData[IN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capDone    <= 1'b0;
      masterAddr <= '0;
      slaveAddr  <= '0;
    end else if (!capDone) begin
      capDone    <= 1'b1;
      masterAddr <= {3'b101, strapMst};
      slaveAddr  <= {2'b11, strapSlv[3], 1'b0, strapSlv[2:0]};
    end
  end

  // R10: addresses frozen after the one-time capture
  p_addr_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    capDone |=> ($stable(masterAddr) && $stable(slaveAddr)));
endmodule

// File: rtl/hpx_hotplug_seq.sv
module hpx_hotplug_seq
  import hpx_pkg::*;
#(
  parameter int         OUT_W    = 8,
  parameter int         IN_W     = 8,
  parameter logic [6:0] EXP_ADDR = 7'h20,
  parameter logic [7:0] OUT_CMD  = 8'h02,
  parameter logic [7:0] IN_CMD   = 8'h00
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgDone,
  input  logic [OUT_W-1:0] hpOut,
  output logic [IN_W-1:0]  hpIn,
  input  logic             expIntN,
  input  logic [3:0]       strapMst,
  input  logic [3:0]       strapSlv,
  output logic [6:0]       masterAddr,
  output logic [6:0]       slaveAddr,
  output logic             smbReq,
  output logic             smbWrite,
  output logic [6:0]       smbAddr,
  output logic [7:0]       smbCmd,
  output logic [7:0]       smbWrData,
  input  logic             smbDone,
  input  logic             smbErr,
  input  logic [7:0]       smbRdData
);
  seqStrobe_t strobe;
  logic       outChanged;
  logic       errFlag;

  assign smbAddr = EXP_ADDR;

  hpx_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgDone(cfgDone), .outChanged(outChanged),
    .expIntN(expIntN), .smbDone(smbDone), .smbErr(smbErr), .strobe(strobe),
    .smbReq(smbReq), .smbWrite(smbWrite), .errFlag(errFlag)
  );

  hpx_dp #(.OUT_W(OUT_W), .IN_W(IN_W), .OUT_CMD(OUT_CMD), .IN_CMD(IN_CMD)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hpOut(hpOut), .smbRdData(smbRdData),
    .strapMst(strapMst), .strapSlv(strapSlv), .outChanged(outChanged),
    .smbCmd(smbCmd), .smbWrData(smbWrData), .hpIn(hpIn),
    .masterAddr(masterAddr), .slaveAddr(slaveAddr)
  );

  // R11: request and its fields held until completion
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (smbReq && !smbDone) |=> (smbReq && $stable(smbWrite) && $stable(smbCmd)
                              && $stable(smbWrData)));

  // R11 / R7: request drops in the cycle after completion
  p_gap_after_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (smbReq && smbDone) |=> !smbReq);

  // R3: input image changes only on a good read completion
  p_hpin_only_on_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(smbReq && smbDone && !smbErr && !smbWrite) |=> $stable(hpIn));
endmodule

// File: tb/test_hpx_hotplug_seq.sv
module test_hpx_hotplug_seq;
  localparam logic [6:0] EXP_ADDR = 7'h20;
  localparam logic [7:0] OUT_CMD  = 8'h02;
  localparam logic [7:0] IN_CMD   = 8'h00;
  localparam int         LAT      = 3;

  logic clk = 0, rstN = 0, cfgDone = 0, expIntN = 1;
  logic [7:0] hpOut = 0, hpIn;
  logic [3:0] strapMst = 4'b1010, strapSlv = 4'b1101;
  logic [6:0] masterAddr, slaveAddr, smbAddr;
  logic smbReq, smbWrite, smbDone = 0, smbErr = 0;
  logic [7:0] smbCmd, smbWrData, smbRdData = 0;

  int vectors = 0, misses = 0, cycles = 0;

  always #2 clk = ~clk;

  hpx_hotplug_seq #(.EXP_ADDR(EXP_ADDR), .OUT_CMD(OUT_CMD), .IN_CMD(IN_CMD)) i_hpx_hotplug_seq (
    .clk(clk), .rstN(rstN), .cfgDone(cfgDone), .hpOut(hpOut), .hpIn(hpIn),
    .expIntN(expIntN), .strapMst(strapMst), .strapSlv(strapSlv),
    .masterAddr(masterAddr), .slaveAddr(slaveAddr), .smbReq(smbReq),
    .smbWrite(smbWrite), .smbAddr(smbAddr), .smbCmd(smbCmd), .smbWrData(smbWrData),
    .smbDone(smbDone), .smbErr(smbErr), .smbRdData(smbRdData)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- expander / engine responder ----------------
  int       latCnt = 0, failLeft = 0, keepLowReads = 0, reqSeen = 0;
  logic [7:0] expInputs = 8'h00, expImage = 8'h00;
  int       log[$];   // 256+data for good write, 512+data for good read

  always @(negedge clk) begin
    if (smbDone) begin
      smbDone <= 0; smbErr <= 0; latCnt = 0;
    end else if (smbReq) begin
      if (latCnt == 0) reqSeen++;
      latCnt++;
      if (latCnt == LAT) begin
        smbDone <= 1;
        smbRdData <= expInputs;
        if (failLeft > 0) begin
          smbErr <= 1; failLeft--;
        end else begin
          smbErr <= 0;
          if (smbWrite) begin
            expImage = smbWrData; log.push_back(256 + smbWrData);
          end else begin
            log.push_back(512 + expInputs);
            if (keepLowReads > 0) keepLowReads--;
            else expIntN <= 1;
          end
        end
      end
    end
  end

  // ---------------- behavioural reference model ----------------
  int       mMode;   // 0 idle, 1 on bus, 2 pause before retry
  bit       mPend, mTry2, mWr, mErr, mCap;
  logic [7:0] mLast, mData, mCmd, mIn;
  logic [6:0] mMst, mSlv;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mPend = 0; mTry2 = 0; mWr = 0; mErr = 0; mCap = 0;
      mLast = 0; mData = 0; mCmd = 0; mIn = 0; mMst = 0; mSlv = 0;
    end else begin
      bit changed, canGo;
      changed = (hpOut != mLast);
      canGo = (mMode == 0) && cfgDone;
      if (!mCap) begin
        mCap = 1;
        mMst = {1'b1, 1'b0, 1'b1, strapMst};
        mSlv = {1'b1, 1'b1, strapSlv[3], 1'b0, strapSlv[2:0]};
      end
      if (mMode == 0) begin
        if (canGo && mPend) begin
          mMode = 1; mWr = 1; mTry2 = 0; mCmd = OUT_CMD; mData = hpOut; mPend = 0;
        end else if (canGo && !expIntN) begin
          mMode = 1; mWr = 0; mTry2 = 0; mCmd = IN_CMD;
        end
      end else if (mMode == 1) begin
        if (smbDone) begin
          if (!smbErr) begin
            if (!mWr) mIn = smbRdData;
            mMode = 0;
          end else if (!mTry2) begin
            mMode = 2; mTry2 = 1;
          end else begin
            mMode = 0; mErr = 1;
          end
        end
      end else mMode = 1;
      if (changed) mPend = 1;
      mLast = hpOut;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    check(smbReq == (mMode == 1), "R11 smbReq", smbReq, mMode == 1);
    if (mMode == 1) begin
      check(smbWrite == mWr, "R5 smbWrite", smbWrite, mWr);
      check(smbCmd == mCmd, "R1 smbCmd", smbCmd, mCmd);
      check(smbAddr == EXP_ADDR, "R1 smbAddr", smbAddr, EXP_ADDR);
      if (mWr) check(smbWrData == mData, "R1 smbWrData", smbWrData, mData);
    end
    check(hpIn == mIn, "R3 hpIn", hpIn, mIn);
    check(i_hpx_hotplug_seq.errFlag == mErr, "R7 errFlag", i_hpx_hotplug_seq.errFlag, mErr);
    check(masterAddr == mMst, "R9 masterAddr", masterAddr, mMst);
    check(slaveAddr == mSlv, "R10 slaveAddr", slaveAddr, mSlv);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // reset state
    idle(3);
    check(smbReq == 0, "R6 req in reset", smbReq, 0);
    check(masterAddr == 0 && slaveAddr == 0, "R10 addr in reset", masterAddr, 0);
    check(i_hpx_hotplug_seq.errFlag == 0, "R8 err after reset", i_hpx_hotplug_seq.errFlag, 0);
    rstN = 1;
    idle(2);
    check(masterAddr == 7'b101_1010, "R9 master strap", masterAddr, 7'b101_1010);
    check(slaveAddr == 7'b11_1_0_101, "R10 slave strap", slaveAddr, 7'b1110101);
    strapMst = 4'b0101; strapSlv = 4'b0010;
    // work requested but configuration not done
    hpOut = 8'h3c; expInputs = 8'h81; expIntN = 0;
    idle(12);
    check(reqSeen == 0, "R6 no req before cfgDone", reqSeen, 0);
    check(masterAddr == 7'b101_1010, "R10 strap change ignored", masterAddr, 7'b1011010);
    // R5: write then read
    cfgDone = 1;
    idle(30);
    check(log.size() == 2, "R5 two transactions", log.size(), 2);
    if (log.size() == 2) begin
      check(log[0] == 256 + 8'h3c, "R1 write full image first", log[0], 256 + 8'h3c);
      check(log[1] == 512 + 8'h81, "R3 read follows", log[1], 512 + 8'h81);
    end
    check(hpIn == 8'h81, "R3 hpIn updated", hpIn, 8'h81);
    log.delete();
    // R2: change during a running write
    hpOut = 8'h01;
    idle(4);
    hpOut = 8'h03;
    idle(30);
    check(log.size() == 2, "R2 second write issued", log.size(), 2);
    check(expImage == 8'h03, "R2 expander holds newest", expImage, 8'h03);
    log.delete();
    // R4: interrupt held low across one read
    expInputs = 8'h5a; keepLowReads = 1; expIntN = 0;
    idle(40);
    check(log.size() == 2, "R4 reread while low", log.size(), 2);
    check(hpIn == 8'h5a, "R4 hpIn", hpIn, 8'h5a);
    log.delete();
    // R7: single error then success
    failLeft = 1; hpOut = 8'hc0;
    idle(30);
    check(expImage == 8'hc0, "R7 retry succeeded", expImage, 8'hc0);
    check(i_hpx_hotplug_seq.errFlag == 0, "R7 no error after good retry", i_hpx_hotplug_seq.errFlag, 0);
    // R7/R8: two errors drop the write
    failLeft = 2; hpOut = 8'h77;
    idle(30);
    check(expImage == 8'hc0, "R7 dropped write", expImage, 8'hc0);
    check(i_hpx_hotplug_seq.errFlag == 1, "R7 error raised", i_hpx_hotplug_seq.errFlag, 1);
    hpOut = 8'h78;
    idle(30);
    check(expImage == 8'h78, "R1 later write works", expImage, 8'h78);
    check(i_hpx_hotplug_seq.errFlag == 1, "R8 error sticky", i_hpx_hotplug_seq.errFlag, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule